// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Edge Interrupts

This block is an eight-pin (parameterised) digital I/O port. Each pin has its own direction bit, its own output level bit and its own steering bit. The steering bit picks either the port's output register or a signal from another on-chip peripheral as the level driven to the pad. A read-only level register returns the state of every pin after a two-flop synchroniser.

Each pin can also raise an interrupt when its input changes. A per-pin polarity bit chooses whether the rising or the falling transition counts. A matching transition latches a per-pin flag, and the flag stays set until software writes it. The flags are masked by a per-pin enable register and combined into one interrupt request line.

Software reaches all registers over a simple single-cycle bus. A write is taken at the clock edge while the write strobe is high. The read data is a combinational function of the address.

Top module: `gpio_edge_port`

## Requirements
- R1: The pad output-enable vector equals the direction register; a 1 makes the pin an output and a 0 makes it an input. The direction register is at address 2.
- R2: Reading address 0 returns the pin levels after two clock edges of synchronisation. Writes to address 0 are ignored.
- R3: When a pin's steering bit (address 3) is 0, the pad output level equals that pin's bit in the output register (address 1).
- R4: When a pin's steering bit is 1, the pad output level equals that pin's peripheral input bit.
- R5: When a pin's polarity bit (address 4) is 0, a low-to-high change sets that pin's flag (address 5). The flag becomes visible after the third clock edge following the pin change.
- R6: When a pin's polarity bit is 1, a high-to-low change sets that pin's flag. A change in the other direction does not set it.
- R7: A pin held at a constant level never sets its flag, however long it is held.
- R8: A flag stays set until it is written. A write to address 5 loads the written value, so a 0 clears a flag and a 1 sets it. A qualifying pin transition in the same cycle as a clearing write leaves the flag set.
- R9: The interrupt request is high exactly when at least one pin has both its flag and its enable bit (address 6) set.
- R10: The output, direction, steering, polarity and enable registers read back the last value written, and all of them reset to 0. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| periph_dout | input | 8 | Peripheral output levels for steered pins |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check four things:
- a direction write appears on the output enables one cycle later;
- steering every pin to the peripheral passes the peripheral levels straight through;
- disabling all enables drops the request;
- no flag is ever lost without a write to the flag register.

Other behaviour needs a chosen pin history, so only the directed scenarios show it:
- the exact cycle in which a flag appears;
- which polarity of transition counts;
- that a long static level stays silent;
- that a same-cycle edge wins over a clearing write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_DRIVE = 3'd1,
        REG_DIR   = 3'd2,
        REG_FSEL  = 3'd3,
        REG_EDGE  = 3'd4,
        REG_FLAG  = 3'd5,
        REG_IEN   = 3'd6,
        REG_NONE  = 3'd7
    } reg_sel_e;

    function automatic logic addr_hit(input logic we, input logic [ADDR_W-1:0] addr,
                                      input reg_sel_e sel);
        return we && (reg_sel_e'(addr) == sel);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] edge_sel,
    input  logic         wr_flag,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise   = level[i] & ~prev_q[i];
        assign fall   = ~level[i] & prev_q[i];
        assign hit[i] = edge_sel[i] ? fall : rise;

        always_ff @(posedge clk) begin
            if (rst)          flag_q[i] <= 1'b0;
            else if (wr_flag) flag_q[i] <= wdata[i] | hit[i];
            else              flag_q[i] <= flag_q[i] | hit[i];
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      drive,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      fsel,
    output logic [W-1:0]      edge_sel,
    output logic [W-1:0]      ien
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drive    <= '0;
            dir      <= '0;
            fsel     <= '0;
            edge_sel <= '0;
            ien      <= '0;
        end else begin
            if (addr_hit(we, addr, REG_DRIVE)) drive    <= wdata;
            if (addr_hit(we, addr, REG_DIR))   dir      <= wdata;
            if (addr_hit(we, addr, REG_FSEL))  fsel     <= wdata;
            if (addr_hit(we, addr, REG_EDGE))  edge_sel <= wdata;
            if (addr_hit(we, addr, REG_IEN))   ien      <= wdata;
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] periph_dout,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    logic [N_PINS-1:0] level_sync;
    logic [N_PINS-1:0] drive_q, dir_q, fsel_q, edge_q, ien_q, flag_q;

    gpio_sync #(.W(N_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(level_sync)
    );

    gpio_ctrl_regs #(.W(N_PINS)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .drive(drive_q), .dir(dir_q), .fsel(fsel_q), .edge_sel(edge_q), .ien(ien_q)
    );

    gpio_edge_flags #(.W(N_PINS)) u_flags (
        .clk(clk), .rst(rst), .level(level_sync), .edge_sel(edge_q),
        .wr_flag(addr_hit(bus_we, bus_addr, REG_FLAG)), .wdata(bus_wdata),
        .flag(flag_q)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_LEVEL: bus_rdata = level_sync;
            REG_DRIVE: bus_rdata = drive_q;
            REG_DIR:   bus_rdata = dir_q;
            REG_FSEL:  bus_rdata = fsel_q;
            REG_EDGE:  bus_rdata = edge_q;
            REG_FLAG:  bus_rdata = flag_q;
            REG_IEN:   bus_rdata = ien_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = (fsel_q & periph_dout) | (~fsel_q & drive_q);
    assign pin_oe  = dir_q;
    assign irq     = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      periph_dout,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      flag_q
);
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_DIR) |=> pin_oe == $past(bus_wdata)); // R1

    AST_PERIPH_PASS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_FSEL && bus_wdata == '1) |=> pin_out == periph_dout); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == REG_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_IEN && bus_wdata == '0) |=> !irq); // R9
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(N_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .periph_dout(periph_dout), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq), .flag_q(flag_q)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] periph_dout = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gpio_edge_port u_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .periph_dout(periph_dout), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_check("R10 reset readback", a[2:0], 8'h00);
        check("R1 reset oe", pin_oe, 8'h00);
        check("R3 reset out", pin_out, 8'h00);
        check("R9 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_direction();
        wr(3'd2, 8'hA5);
        check("R1 oe follows dir", pin_oe, 8'hA5);
        rd_check("R10 dir readback", 3'd2, 8'hA5);
        wr(3'd6, 8'h00);
        rd_check("R10 ien readback", 3'd6, 8'h00);
        rd_check("R10 addr7 zero", 3'd7, 8'h00);
    endtask

    task automatic t_io_out();
        wr(3'd1, 8'h3C);
        periph_dout = 8'hC3;
        #1;
        check("R3 io drive", pin_out, 8'h3C);
        rd_check("R10 drive readback", 3'd1, 8'h3C);
    endtask

    task automatic t_periph();
        wr(3'd3, 8'hF0);
        check("R4 mixed steering", pin_out, 8'hCC);
        rd_check("R10 fsel readback", 3'd3, 8'hF0);
        wr(3'd3, 8'h00);
        check("R3 back to io", pin_out, 8'h3C);
    endtask

    task automatic t_level();
        pin_in = 8'h5A;
        step(1);
        rd_check("R2 level after 1 edge", 3'd0, 8'h00);
        step(1);
        rd_check("R2 level after 2 edges", 3'd0, 8'h5A);
        wr(3'd0, 8'hFF);
        rd_check("R2 level write ignored", 3'd0, 8'h5A);
        step(2);
        rd_check("R5 flags from rising 5A", 3'd5, 8'h5A);
        pin_in = 8'h00;
        step(4);
        wr(3'd5, 8'h00);
        rd_check("R8 clear all", 3'd5, 8'h00);
    endtask

    task automatic t_rising();
        pin_in = 8'h01;
        step(2);
        rd_check("R5 flag not before third edge", 3'd5, 8'h00);
        step(1);
        rd_check("R5 rising flag", 3'd5, 8'h01);
    endtask

    task automatic t_falling();
        wr(3'd4, 8'h02);
        rd_check("R10 edge readback", 3'd4, 8'h02);
        pin_in = 8'h03;
        step(3);
        rd_check("R6 rise ignored on falling pin", 3'd5, 8'h01);
        pin_in = 8'h01;
        step(3);
        rd_check("R6 falling flag", 3'd5, 8'h03);
    endtask

    task automatic t_static_and_write();
        wr(3'd5, 8'h02);
        rd_check("R8 write 0 clears one", 3'd5, 8'h02);
        step(8);
        rd_check("R7 static high no flag", 3'd5, 8'h02);
        wr(3'd5, 8'h82);
        rd_check("R8 write 1 sets", 3'd5, 8'h82);
        step(3);
        rd_check("R8 flags stay set", 3'd5, 8'h82);
        wr(3'd5, 8'h00);
        pin_in = 8'h05;
        step(2);
        wr(3'd5, 8'h00);
        rd_check("R8 edge beats clear", 3'd5, 8'h04);
    endtask

    task automatic t_irq();
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(3'd6, 8'h04);
        check("R9 irq enabled pin", {7'd0, irq}, 8'h01);
        wr(3'd6, 8'hFB);
        check("R9 irq other pins only", {7'd0, irq}, 8'h00);
        wr(3'd6, 8'h04);
        wr(3'd5, 8'h00);
        check("R9 irq after clear", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_direction();
        t_io_out();
        t_periph();
        t_level();
        t_rising();
        t_falling();
        t_static_and_write();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule